// File: doc/BRIEF.md
# Normal Interrupt Priority Resolver

This block picks, from a 64-bit vector of candidate interrupt sources (sources that are pending, enabled and routed to the normal, not the fast, request line), the single source that should be serviced next. Each source carries a 4-bit priority taken from a bank of eight 32-bit priority words. A source is chosen by the larger priority value; equal priorities are broken in favour of the larger source number. The winner's valid flag, index and priority leave the block continuously, two clock cycles after the candidate and priority inputs they describe.

A bus read of the status location is presented as a level request that stalls until the block answers. The answer is a 32-bit status word that carries the winning index in its upper half and the winning priority in its lowest bits, or all ones when nothing is waiting. In the same cycle the block emits a one-hot clear vector naming the winner, so that the pending storage outside drops that source. Reading the status therefore consumes the winner.

Top module: `nirq_resolver`

## Requirements
- R1: The priority of source n is the 4-bit field starting at bit 4*(n mod 8) of priority word n/8, where word k occupies bits 32*k+31 down to 32*k of `prioFlat`.
- R2: When candidates exist, `resValid` is 1 and `resIdx`/`resPrio` name the candidate whose priority value is numerically largest.
- R3: Among candidates sharing the largest priority, the one with the largest source number is reported.
- R4: A lone candidate whose priority is 0 is still reported as a valid winner with priority 0.
- R5: With no candidate, `resValid` is 0, and a status read returns 0xFFFFFFFF with an all-zero `clrPulse`.
- R6: A status read that finds a winner returns the index in bits 31:16, the priority in bits 3:0, and zero in bits 15:4.
- R7: When `rdReq` is high while the block is idle at a clock edge, `rdAck` is low after that edge, high for exactly one cycle after the next edge, and low again after the one following.
- R8: `clrPulse` is zero except in the cycle `rdAck` is high; there it has exactly one bit set, at the reported index, when a winner exists.
- R9: `resValid`, `resIdx` and `resPrio` reflect the inputs present two rising clock edges earlier.
- R10: While `rstN` is low, `resValid`, `rdAck` and `clrPulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| candVec | input | 64 | Candidate sources (pending, enabled, normal line) |
| prioFlat | input | 256 | Eight 32-bit priority words, word 0 in the low bits |
| rdReq | input | 1 | Status read request, held until acknowledged |
| rdAck | output | 1 | One-cycle read completion |
| rdData | output | 32 | Status word, valid while `rdAck` is high |
| clrPulse | output | 64 | One-hot clear for the winner's pending bit |
| resValid | output | 1 | A winner exists |
| resIdx | output | 6 | Winning source number |
| resPrio | output | 4 | Winning priority |

## Verification
The selection is swept with every source alone at every priority, which separates the field mapping from the comparison and shows that priority 0 is still selectable. All-equal vectors and every pair of sources at equal and at unequal priority tell the tie rule apart from the magnitude rule, in both index orders. Random vectors with a narrow priority range exercise many simultaneous ties against an arithmetic model, while status reads on random and empty vectors check the word format, the one-hot clear and the two-cycle stall.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NUM_SRC        = 64;
  localparam int PRIO_W         = 4;
  localparam int WORD_W         = 32;
  localparam int SLOTS_PER_WORD = WORD_W / PRIO_W;
  localparam int NUM_WORDS      = NUM_SRC / SLOTS_PER_WORD;
  localparam int IDX_W          = $clog2(NUM_SRC);
  localparam int STAT_W         = 32;
  localparam int IDX_LSB        = 16;
  localparam int TREE_LVLS      = IDX_W;
  localparam int MID_LVL        = TREE_LVLS / 2;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    logic [PRIO_W-1:0] prio;
  } node_t;

  typedef struct packed {
    logic respond;
  } ctrlStrobe_t;

  // Upper child wins ties so the larger source number prevails.
  function automatic node_t pickNode(input node_t lo, input node_t hi);
    if (hi.valid && (!lo.valid || hi.prio >= lo.prio)) return hi;
    return lo;
  endfunction

  function automatic int nodeDepth(input int n);
    int d;
    d = 0;
    while ((1 << (d + 1)) <= n) d++;
    return d;
  endfunction
endpackage

// File: rtl/nirq_tree.sv
module nirq_tree
  import nirq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          candVec,
  input  logic [NUM_WORDS*WORD_W-1:0] prioFlat,
  input  ctrlStrobe_t                 strobe,
  output logic                        resValid,
  output logic [IDX_W-1:0]            resIdx,
  output logic [PRIO_W-1:0]           resPrio,
  output logic [STAT_W-1:0]           statWord,
  output logic [NUM_SRC-1:0]          clrPulse
);
  localparam int MID_BASE  = 1 << MID_LVL;
  localparam int MID_NODES = 1 << MID_LVL;
  localparam int HEAP_TOP  = 2 * NUM_SRC - 1;

  node_t heap [1:HEAP_TOP];
  node_t midQ [0:MID_NODES-1];
  node_t resQ;

  // Leaves: source i sits at heap position NUM_SRC+i.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    localparam int WRD  = i / SLOTS_PER_WORD;
    localparam int SLOT = i % SLOTS_PER_WORD;
    assign heap[NUM_SRC+i] = node_t'{
      valid: candVec[i],
      idx:   IDX_W'(i),
      prio:  prioFlat[WRD*WORD_W + SLOT*PRIO_W +: PRIO_W]
    };
  end

  // Inner nodes: combinational except the registered midpoint level.
  for (genvar n = 1; n < NUM_SRC; n++) begin : g_node
    if (nodeDepth(n) == MID_LVL) begin : g_mid
      assign heap[n] = midQ[n-MID_BASE];
    end else begin : g_comb
      assign heap[n] = pickNode(heap[2*n], heap[2*n+1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MID_NODES; k++) midQ[k] <= '0;
      resQ <= '0;
    end else begin
      for (int k = 0; k < MID_NODES; k++)
        midQ[k] <= pickNode(heap[2*(MID_BASE+k)], heap[2*(MID_BASE+k)+1]);
      resQ <= heap[1];
    end
  end

  assign resValid = resQ.valid;
  assign resIdx   = resQ.idx;
  assign resPrio  = resQ.prio;

  always_comb begin
    statWord = '0;
    clrPulse = '0;
    if (strobe.respond) begin
      if (resQ.valid) begin
        statWord = (STAT_W'(resQ.idx) << IDX_LSB) | STAT_W'(resQ.prio);
        clrPulse[resQ.idx] = 1'b1;
      end else begin
        statWord = '1;
      end
    end
  end

  // Checks local to the datapath.
  logic [1:0] primeCnt;
  always_ff @(posedge clk) begin
    if (!rstN) primeCnt <= '0;
    else if (primeCnt != 2'd2) primeCnt <= primeCnt + 2'd1;
  end

  a_r9_valid_follows_inputs: assert property (@(posedge clk) disable iff (!rstN)
    (primeCnt == 2'd2) |-> (resValid == (|$past(candVec, 2))));

  a_r8_clear_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrPulse));

  a_r8_clear_at_winner: assert property (@(posedge clk) disable iff (!rstN)
    (|clrPulse) |-> (strobe.respond && resValid && clrPulse[resIdx]));

  a_r5_empty_status: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respond && !resValid) |-> (statWord == '1 && clrPulse == '0));
endmodule

// File: rtl/nirq_ctrl.sv
module nirq_ctrl
  import nirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  output logic        rdAck,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_RESPOND} rdState_t;
  rdState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    if (rdReq) state <= ST_LOOKUP;
        ST_LOOKUP:  state <= ST_RESPOND;
        ST_RESPOND: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign rdAck          = (state == ST_RESPOND);
  assign strobe.respond = (state == ST_RESPOND);

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |=> !rdAck);

  a_r7_ack_two_later: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdReq) |=> (!rdAck ##1 rdAck));
endmodule

// File: rtl/nirq_resolver.sv
module nirq_resolver
  import nirq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          candVec,
  input  logic [NUM_WORDS*WORD_W-1:0] prioFlat,
  input  logic                        rdReq,
  output logic                        rdAck,
  output logic [STAT_W-1:0]           rdData,
  output logic [NUM_SRC-1:0]          clrPulse,
  output logic                        resValid,
  output logic [IDX_W-1:0]            resIdx,
  output logic [PRIO_W-1:0]           resPrio
);
  ctrlStrobe_t strobe;

  nirq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdReq  (rdReq),
    .rdAck  (rdAck),
    .strobe (strobe)
  );

  nirq_tree u_tree (
    .clk      (clk),
    .rstN     (rstN),
    .candVec  (candVec),
    .prioFlat (prioFlat),
    .strobe   (strobe),
    .resValid (resValid),
    .resIdx   (resIdx),
    .resPrio  (resPrio),
    .statWord (rdData),
    .clrPulse (clrPulse)
  );

  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rstN |=> (!rdAck && clrPulse == '0 && !resValid) || !rstN);
endmodule

// File: tb/tb_nirq_resolver.sv
module tb_nirq_resolver;
  logic         clk = 1'b0;
  logic         rstN;
  logic [63:0]  candVec;
  logic [255:0] prioFlat;
  logic         rdReq;
  logic         rdAck;
  logic [31:0]  rdData;
  logic [63:0]  clrPulse;
  logic         resValid;
  logic [5:0]   resIdx;
  logic [3:0]   resPrio;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  nirq_resolver dut (
    .clk(clk), .rstN(rstN), .candVec(candVec), .prioFlat(prioFlat),
    .rdReq(rdReq), .rdAck(rdAck), .rdData(rdData), .clrPulse(clrPulse),
    .resValid(resValid), .resIdx(resIdx), .resPrio(resPrio)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: priority of n is the nibble at 4*(n mod 8) of word n/8.
  function automatic logic [3:0] prioOf(input logic [255:0] pf, input int n);
    return pf[(n / 8) * 32 + 4 * (n % 8) +: 4];
  endfunction

  function automatic void model(input logic [63:0] cv, input logic [255:0] pf,
                                output bit v, output int idx, output int pr);
    v = 0; idx = 0; pr = -1;
    for (int n = 0; n < 64; n++)
      if (cv[n] && int'(prioOf(pf, n)) >= pr) begin
        v = 1; idx = n; pr = int'(prioOf(pf, n));
      end
    if (!v) pr = 0;
  endfunction

  function automatic logic [255:0] randPrio(input int span);
    logic [255:0] pf;
    for (int n = 0; n < 64; n++) pf[4*n +: 4] = 4'($urandom % span);
    return pf;
  endfunction

  // Drive at negedge, result visible after two rising edges.
  task automatic applyCheck(input logic [63:0] cv, input logic [255:0] pf,
                            input string req);
    bit v; int idx; int pr;
    candVec = cv; prioFlat = pf;
    model(cv, pf, v, idx, pr);
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (v)
      chk(resValid && resIdx == 6'(idx) && resPrio == 4'(pr), req,
          {53'b0, resValid, resIdx, resPrio}, {53'b0, 1'b1, 6'(idx), 4'(pr)});
    else
      chk(!resValid, req, {63'b0, resValid}, 64'd0);
  endtask

  task automatic doRead(input string req);
    bit v; int idx; int pr;
    logic [31:0] expData;
    logic [63:0] expClr;
    model(candVec, prioFlat, v, idx, pr);
    expData = v ? ((32'(idx) << 16) | 32'(pr)) : 32'hFFFF_FFFF;
    expClr  = v ? (64'd1 << idx) : 64'd0;
    rdReq = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!rdAck && clrPulse == 0, {req, " R7 stall"}, {63'b0, rdAck}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk(rdAck, {req, " R7 ack"}, {63'b0, rdAck}, 64'd1);
    chk(rdData == expData, {req, " R6 status"}, {32'b0, rdData}, {32'b0, expData});
    chk(clrPulse == expClr, {req, " R8 clear"}, clrPulse, expClr);
    rdReq = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!rdAck && clrPulse == 0, {req, " R7 R8 single"}, clrPulse | 64'(rdAck), 64'd0);
  endtask

  initial begin
    logic [255:0] pf;
    rstN = 1'b0; candVec = '1; prioFlat = '1; rdReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!resValid && !rdAck && clrPulse == 0, "R10 reset",
        clrPulse | 64'(resValid) | 64'(rdAck), 64'd0);
    rstN = 1'b1;

    // R1 R4: each source alone, every priority, random neighbours.
    for (int n = 0; n < 64; n++)
      for (int p = 0; p < 16; p++) begin
        pf = randPrio(16);
        pf[(n / 8) * 32 + 4 * (n % 8) +: 4] = 4'(p);
        applyCheck(64'd1 << n, pf, p == 0 ? "R4 zero prio alone" : "R1 field map");
      end

    // R5: empty vector.
    applyCheck(64'd0, randPrio(16), "R5 empty valid");
    doRead("R5 empty read");

    // R3: all sources at one level.
    for (int p = 0; p < 16; p++) applyCheck('1, {64{4'(p)}}, "R3 all equal");

    // R2 R3: every pair, equal and unequal priorities.
    for (int a = 0; a < 64; a++)
      for (int b = a + 1; b < 64; b++) begin
        pf = randPrio(16);
        if ((a + b) % 2 == 0)
          pf[(b / 8) * 32 + 4 * (b % 8) +: 4] = prioOf(pf, a);
        applyCheck((64'd1 << a) | (64'd1 << b), pf,
                   (a + b) % 2 == 0 ? "R3 pair tie" : "R2 pair order");
      end

    // R2 R3 R9: random dense vectors with narrow priorities.
    for (int k = 0; k < 400; k++)
      applyCheck({$urandom, $urandom}, randPrio(k % 2 ? 3 : 16), "R2 R9 random");

    // R6 R7 R8: status reads.
    for (int k = 0; k < 40; k++) begin
      candVec = (k % 8 == 0) ? 64'd0 : {$urandom, $urandom} & {$urandom, $urandom};
      prioFlat = randPrio(k % 2 ? 2 : 16);
      @(posedge clk); @(posedge clk); @(negedge clk);
      doRead("R6 read");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule